// File: doc/BRIEF.md
# Segment Register Descriptor Loader

This block serves a request to place a 16-bit selector into one of six segment registers. It splits the selector into a table index, a table choice bit and a requested privilege field. It uses the table choice bit to pick either the global or the local descriptor table, and forms the byte address of the 8-byte descriptor from that table's base. It fetches the descriptor as two 32-bit words over a request/acknowledge read port. It then rebuilds the base address from three pieces and the limit from two, checks the present bit, and writes the selector and the rebuilt descriptor into the chosen register.

A null selector (index zero in the global table) is accepted without any memory traffic for the four data registers, and marks the register as null so that a later access through it can be trapped. The same selector is refused for the code and stack registers. A selector whose descriptor would run past the selected table's limit is refused before any read is made. Each request ends with a one-cycle `done` pulse and a two-bit fault code. A registered read port gives the address translator each register's stored contents.

Top module: `seg_load_unit`

## Requirements
- R1: After reset, `done` and `mem_req` are low, and every register reads back selector 0, base 0, limit 0, attributes 0 and null flag 1.
- R2: For a selector with bits 15..3 as index and bit 2 as table choice (0 global, 1 local), the first read address is the chosen table base plus index times 8, and the second read address is 4 above the first.
- R3: From low word L and high word H, the stored base is {H[31:24], H[7:0], L[31:16]} and the stored limit is {H[19:16], L[15:0]}.
- R4: The attribute read-out is {H[23] granularity, H[15] present, H[14:13] privilege, H[12] segment kind, H[11:8] type}, 9 bits in that order, MSB first.
- R5: A selector with index 0 and table choice 0 loaded into a data register (numbers 2 to 5) finishes with fault 0 and `done` one cycle after the request, issues no read, stores the selector and sets the null flag. Index 0 with table choice 1 is not null and is fetched.
- R6: A null selector loaded into the code register (number 0) or the stack register (number 1) finishes with fault 1, issues no read, and leaves that register unchanged.
- R7: When index*8+7 exceeds the chosen table limit, the load finishes with fault 2 one cycle after the request and issues no read. A value equal to the limit is allowed.
- R8: A fetched descriptor with the present bit clear finishes with fault 3 and leaves the target register unchanged.
- R9: `done` is high for exactly one cycle per accepted request, with `fault_code` valid in that cycle, and `mem_req` is low whenever `done` is high.
- R10: A request raised while a fetch is in progress is ignored: it writes no register and adds no `done` pulse.
- R11: A successful descriptor load stores the selector, base, limit and attributes, and clears the null flag with fault 0.
- R12: `mem_req` stays high with a stable address until `mem_ack`. It drops after the second word is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_req | input | 1 | Load request, sampled while idle |
| ld_reg | input | REG_W | Target register number (0 code, 1 stack, 2..5 data) |
| ld_sel | input | 16 | Selector to load |
| gtab_base | input | 32 | Global table base address |
| gtab_lim | input | TLIM_W | Global table limit in bytes |
| ltab_base | input | 32 | Local table base address |
| ltab_lim | input | TLIM_W | Local table limit in bytes |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | 32 | Memory read byte address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 32 | Read data word |
| done | output | 1 | One-cycle completion pulse |
| fault_code | output | 2 | 0 none, 1 null into code/stack, 2 table limit, 3 not present |
| rd_idx | input | REG_W | Register number for the read-out port |
| rd_sel | output | 16 | Stored selector (one cycle after rd_idx) |
| rd_base | output | 32 | Stored base |
| rd_limit | output | 20 | Stored limit |
| rd_attr | output | 9 | Stored attributes |
| rd_null | output | 1 | Stored null flag |

## Verification
The bench builds the block with its default parameters: six registers, code register 0, stack register 1 and 16-bit table limits. With these values, small global (0x3F) and local (0x1F) limits put both sides of the limit boundary within a handful of descriptors. The bench's memory model adds zero, two or four wait states, so both back-to-back acknowledges and held requests are exercised. It also raises a second request during a slow fetch to show that the request is ignored.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int ADDR_W = 32;
  localparam int WORD_W = 32;
  localparam int SEL_W  = 16;
  localparam int LIM_W  = 20;
  localparam int ATTR_W = 9;

  typedef enum logic [1:0] {
    FLT_NONE  = 2'd0,
    FLT_NULLX = 2'd1,
    FLT_TLIM  = 2'd2,
    FLT_ABSNT = 2'd3
  } flt_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RD_LO = 2'd1,
    ST_RD_HI = 2'd2,
    ST_CHECK = 2'd3
  } ld_st_e;

  typedef struct packed {
    logic [ADDR_W-1:0] base;
    logic [LIM_W-1:0]  limit;
    logic              gran;
    logic              pres;
    logic [1:0]        dpl;
    logic              sys_n;
    logic [3:0]        kind;
  } seg_desc_t;
endpackage

// File: rtl/seg_sel_decode.sv
module seg_sel_decode
  import seg_pkg::*;
#(
  parameter int TLIM_W = 16
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [ADDR_W-1:0] gbase,
  input  logic [TLIM_W-1:0] glim,
  input  logic [ADDR_W-1:0] lbase,
  input  logic [TLIM_W-1:0] llim,
  output logic              is_null,
  output logic              lim_fault,
  output logic [ADDR_W-1:0] tbl_addr
);
  localparam int IDX_W = SEL_W - 3;
  localparam int CMP_W = (TLIM_W > SEL_W) ? TLIM_W : SEL_W;

  logic [IDX_W-1:0]  idx;
  logic              ti;
  logic [SEL_W-1:0]  last_byte;
  logic [TLIM_W-1:0] lim;
  logic [CMP_W-1:0]  last_ext;
  logic [CMP_W-1:0]  lim_ext;

  always_comb begin
    idx       = sel[SEL_W-1:3];
    ti        = sel[2];
    last_byte = {idx, 3'b111};
    lim       = ti ? llim : glim;
    last_ext  = CMP_W'(last_byte);
    lim_ext   = CMP_W'(lim);
    lim_fault = last_ext > lim_ext;
    is_null   = (idx == '0) && !ti;
    tbl_addr  = (ti ? lbase : gbase) + ADDR_W'({idx, 3'b000});
  end
endmodule

// File: rtl/seg_desc_unpack.sv
module seg_desc_unpack
  import seg_pkg::*;
(
  input  logic [WORD_W-1:0] lo_word,
  input  logic [WORD_W-1:0] hi_word,
  output seg_desc_t         desc
);
  always_comb begin
    desc.base  = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
    desc.limit = {hi_word[19:16], lo_word[15:0]};
    desc.gran  = hi_word[23];
    desc.pres  = hi_word[15];
    desc.dpl   = hi_word[14:13];
    desc.sys_n = hi_word[12];
    desc.kind  = hi_word[11:8];
  end
endmodule

// File: rtl/seg_reg_file.sv
module seg_reg_file
  import seg_pkg::*;
#(
  parameter int NUM_SEG = 6,
  parameter int REG_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [REG_W-1:0]  widx,
  input  logic [SEL_W-1:0]  wsel,
  input  seg_desc_t         wdesc,
  input  logic              wnull,
  input  logic [REG_W-1:0]  ridx,
  output logic [SEL_W-1:0]  rsel,
  output seg_desc_t         rdesc,
  output logic              rnull
);
  logic [SEL_W-1:0]   sel_q  [NUM_SEG];
  seg_desc_t          desc_q [NUM_SEG];
  logic [NUM_SEG-1:0] null_q;
  logic [NUM_SEG-1:0] hit;

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_hit
    assign hit[i] = we && (widx == REG_W'(i));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_SEG; i++) begin
        sel_q[i]  <= '0;
        desc_q[i] <= '0;
      end
      null_q <= '1;
    end else begin
      for (int i = 0; i < NUM_SEG; i++) begin
        if (hit[i]) begin
          sel_q[i]  <= wsel;
          desc_q[i] <= wdesc;
          null_q[i] <= wnull;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsel  <= '0;
      rdesc <= '0;
      rnull <= 1'b1;
    end else if (int'(ridx) < NUM_SEG) begin
      rsel  <= sel_q[ridx];
      rdesc <= desc_q[ridx];
      rnull <= null_q[ridx];
    end else begin
      rsel  <= '0;
      rdesc <= '0;
      rnull <= 1'b1;
    end
  end
endmodule

// File: rtl/seg_load_unit.sv
module seg_load_unit
  import seg_pkg::*;
#(
  parameter int NUM_SEG   = 6,
  parameter int CODE_SEG  = 0,
  parameter int STACK_SEG = 1,
  parameter int TLIM_W    = 16,
  localparam int REG_W    = $clog2(NUM_SEG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_req,
  input  logic [REG_W-1:0]  ld_reg,
  input  logic [15:0]       ld_sel,
  input  logic [31:0]       gtab_base,
  input  logic [TLIM_W-1:0] gtab_lim,
  input  logic [31:0]       ltab_base,
  input  logic [TLIM_W-1:0] ltab_lim,
  output logic              mem_req,
  output logic [31:0]       mem_addr,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              done,
  output logic [1:0]        fault_code,
  input  logic [REG_W-1:0]  rd_idx,
  output logic [15:0]       rd_sel,
  output logic [31:0]       rd_base,
  output logic [19:0]       rd_limit,
  output logic [8:0]        rd_attr,
  output logic              rd_null
);
  ld_st_e            st_q;
  logic [REG_W-1:0]  reg_q;
  logic [SEL_W-1:0]  sel_q;
  logic [WORD_W-1:0] lo_q;
  logic [WORD_W-1:0] hi_q;
  flt_e              flt_q;

  logic              dec_null;
  logic              dec_lim;
  logic [ADDR_W-1:0] dec_addr;
  seg_desc_t         fetched;
  logic              tgt_fixed;

  logic              wr_en;
  logic [REG_W-1:0]  wr_idx;
  logic [SEL_W-1:0]  wr_sel;
  seg_desc_t         wr_desc;
  logic              wr_null;
  seg_desc_t         rd_desc;

  seg_sel_decode #(.TLIM_W(TLIM_W)) u_dec (
    .sel       (ld_sel),
    .gbase     (gtab_base),
    .glim      (gtab_lim),
    .lbase     (ltab_base),
    .llim      (ltab_lim),
    .is_null   (dec_null),
    .lim_fault (dec_lim),
    .tbl_addr  (dec_addr)
  );

  seg_desc_unpack u_unpack (
    .lo_word (lo_q),
    .hi_word (hi_q),
    .desc    (fetched)
  );

  always_comb begin
    tgt_fixed = (ld_reg == REG_W'(CODE_SEG)) || (ld_reg == REG_W'(STACK_SEG));
    if (st_q == ST_IDLE) begin
      wr_en   = ld_req && dec_null && !tgt_fixed;
      wr_idx  = ld_reg;
      wr_sel  = ld_sel;
      wr_desc = '0;
      wr_null = 1'b1;
    end else begin
      wr_en   = (st_q == ST_CHECK) && fetched.pres;
      wr_idx  = reg_q;
      wr_sel  = sel_q;
      wr_desc = fetched;
      wr_null = 1'b0;
    end
  end

  seg_reg_file #(.NUM_SEG(NUM_SEG), .REG_W(REG_W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_en),
    .widx  (wr_idx),
    .wsel  (wr_sel),
    .wdesc (wr_desc),
    .wnull (wr_null),
    .ridx  (rd_idx),
    .rsel  (rd_sel),
    .rdesc (rd_desc),
    .rnull (rd_null)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      reg_q    <= '0;
      sel_q    <= '0;
      lo_q     <= '0;
      hi_q     <= '0;
      mem_req  <= 1'b0;
      mem_addr <= '0;
      done     <= 1'b0;
      flt_q    <= FLT_NONE;
    end else begin
      done <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (ld_req) begin
            reg_q <= ld_reg;
            sel_q <= ld_sel;
            if (dec_null) begin
              done  <= 1'b1;
              flt_q <= tgt_fixed ? FLT_NULLX : FLT_NONE;
            end else if (dec_lim) begin
              done  <= 1'b1;
              flt_q <= FLT_TLIM;
            end else begin
              mem_req  <= 1'b1;
              mem_addr <= dec_addr;
              st_q     <= ST_RD_LO;
            end
          end
        end
        ST_RD_LO: begin
          if (mem_ack) begin
            lo_q     <= mem_rdata;
            mem_addr <= mem_addr + 32'd4;
            st_q     <= ST_RD_HI;
          end
        end
        ST_RD_HI: begin
          if (mem_ack) begin
            hi_q    <= mem_rdata;
            mem_req <= 1'b0;
            st_q    <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          done  <= 1'b1;
          flt_q <= fetched.pres ? FLT_NONE : FLT_ABSNT;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign fault_code = flt_q;
  assign rd_base    = rd_desc.base;
  assign rd_limit   = rd_desc.limit;
  assign rd_attr    = {rd_desc.gran, rd_desc.pres, rd_desc.dpl, rd_desc.sys_n, rd_desc.kind};
endmodule

// File: rtl/seg_load_chk.sv
module seg_load_chk
  import seg_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input ld_st_e      st,
  input logic        mem_req,
  input logic        mem_ack,
  input logic [31:0] mem_addr,
  input logic        done
);
  p_hold_req_r12: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr));

  p_drop_after_hi_r12: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RD_HI) && mem_ack |=> !mem_req);

  p_second_word_r2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_RD_LO) && mem_ack |=> mem_req && (mem_addr == $past(mem_addr) + 32'd4));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_done_no_req_r9: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req);
endmodule

bind seg_load_unit seg_load_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .st       (st_q),
  .mem_req  (mem_req),
  .mem_ack  (mem_ack),
  .mem_addr (mem_addr),
  .done     (done)
);

// File: tb/tb_seg_load_unit.sv
module tb_seg_load_unit;
  import seg_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_req = 1'b0;
  logic [2:0]  ld_reg = '0;
  logic [15:0] ld_sel = '0;
  logic [31:0] gtab_base = 32'h0000_0100;
  logic [15:0] gtab_lim  = 16'h003F;
  logic [31:0] ltab_base = 32'h0000_0200;
  logic [15:0] ltab_lim  = 16'h001F;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        done;
  logic [1:0]  fault_code;
  logic [2:0]  rd_idx = '0;
  logic [15:0] rd_sel;
  logic [31:0] rd_base;
  logic [19:0] rd_limit;
  logic [8:0]  rd_attr;
  logic        rd_null;

  always #2 clk = ~clk;

  seg_load_unit dut (
    .clk(clk), .rst(rst), .ld_req(ld_req), .ld_reg(ld_reg), .ld_sel(ld_sel),
    .gtab_base(gtab_base), .gtab_lim(gtab_lim), .ltab_base(ltab_base), .ltab_lim(ltab_lim),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .done(done), .fault_code(fault_code), .rd_idx(rd_idx), .rd_sel(rd_sel),
    .rd_base(rd_base), .rd_limit(rd_limit), .rd_attr(rd_attr), .rd_null(rd_null)
  );

  logic [31:0] mem [0:255];
  logic [31:0] ack_addr [0:63];
  int wait_cyc = 0;
  int wcnt = 0;
  int ack_cnt = 0;
  int done_cnt = 0;
  int n_chk = 0;
  int n_err = 0;

  always @(negedge clk) begin
    if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req) begin
      if (wcnt >= wait_cyc) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[9:2]];
        ack_addr[ack_cnt % 64] <= mem_addr;
        ack_cnt   <= ack_cnt + 1;
        wcnt      <= 0;
      end else wcnt <= wcnt + 1;
    end
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] a, input logic [31:0] b, input logic [19:0] l,
                          input logic g, input logic p, input logic [1:0] dpl,
                          input logic s, input logic [3:0] t);
    mem[a[9:2]]     = {b[15:0], l[15:0]};
    mem[a[9:2] + 1] = {b[31:24], g, 3'b000, l[19:16], p, dpl, s, t, b[23:16]};
  endtask

  task automatic do_load(input logic [2:0] r, input logic [15:0] s,
                         output logic [1:0] f, output int lat, output int acks, output int a0);
    int d0;
    @(negedge clk);
    a0 = ack_cnt; d0 = done_cnt;
    ld_reg = r; ld_sel = s; ld_req = 1'b1;
    @(negedge clk);
    ld_req = 1'b0;
    lat = 1;
    while (!done && lat < 100) begin @(negedge clk); lat++; end
    f = fault_code;
    repeat (3) @(negedge clk);
    #1;
    acks = ack_cnt - a0;
    check("R9 one done pulse", 64'(done_cnt - d0), 64'd1);
  endtask

  task automatic read_reg(input logic [2:0] r);
    @(negedge clk);
    rd_idx = r;
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset;
    check("R1 done low", 64'(done), 64'd0);
    check("R1 req low", 64'(mem_req), 64'd0);
    for (int i = 0; i < 6; i++) begin
      read_reg(3'(i));
      check("R1 sel", 64'(rd_sel), 64'd0);
      check("R1 base/limit/attr", {rd_base, 3'b0, rd_limit, rd_attr}, 64'd0);
      check("R1 null", 64'(rd_null), 64'd1);
    end
  endtask

  task automatic t_gdt_load;
    logic [1:0] f; int lat, acks, a0;
    wait_cyc = 0;
    put_desc(32'h110, 32'h1234_5678, 20'hABCDE, 1'b1, 1'b1, 2'b10, 1'b1, 4'hA);
    do_load(3'd3, 16'h0013, f, lat, acks, a0);
    check("R11 fault", 64'(f), 64'd0);
    check("R2 acks", 64'(acks), 64'd2);
    check("R2 lo addr", 64'(ack_addr[a0 % 64]), 64'h110);
    check("R2 hi addr", 64'(ack_addr[(a0 + 1) % 64]), 64'h114);
    read_reg(3'd3);
    check("R11 sel", 64'(rd_sel), 64'h0013);
    check("R3 base", 64'(rd_base), 64'h1234_5678);
    check("R3 limit", 64'(rd_limit), 64'hABCDE);
    check("R4 attr", 64'(rd_attr), 64'(9'b1_1_10_1_1010));
    check("R11 null cleared", 64'(rd_null), 64'd0);
  endtask

  task automatic t_ldt_load;
    logic [1:0] f; int lat, acks, a0;
    wait_cyc = 2;
    put_desc(32'h208, 32'h80FF_0024, 20'h00123, 1'b0, 1'b1, 2'b00, 1'b0, 4'h2);
    do_load(3'd0, 16'h000C, f, lat, acks, a0);
    check("R12 fault with waits", 64'(f), 64'd0);
    check("R2 ldt lo addr", 64'(ack_addr[a0 % 64]), 64'h208);
    check("R2 ldt hi addr", 64'(ack_addr[(a0 + 1) % 64]), 64'h20C);
    read_reg(3'd0);
    check("R3 ldt base", 64'(rd_base), 64'h80FF_0024);
    check("R3 ldt limit", 64'(rd_limit), 64'h00123);
    check("R4 ldt attr", 64'(rd_attr), 64'(9'b0_1_00_0_0010));
    wait_cyc = 0;
  endtask

  task automatic t_null_data;
    logic [1:0] f; int lat, acks, a0;
    do_load(3'd5, 16'h0002, f, lat, acks, a0);
    check("R5 fault", 64'(f), 64'd0);
    check("R5 latency", 64'(lat), 64'd1);
    check("R5 no read", 64'(acks), 64'd0);
    read_reg(3'd5);
    check("R5 sel", 64'(rd_sel), 64'h0002);
    check("R5 null flag", 64'(rd_null), 64'd1);
    put_desc(32'h200, 32'h0000_4000, 20'h00FFF, 1'b0, 1'b1, 2'b11, 1'b1, 4'h3);
    do_load(3'd4, 16'h0004, f, lat, acks, a0);
    check("R5 ldt index0 fetched", 64'(acks), 64'd2);
    check("R5 ldt index0 addr", 64'(ack_addr[a0 % 64]), 64'h200);
    read_reg(3'd4);
    check("R5 ldt index0 not null", 64'(rd_null), 64'd0);
    check("R5 ldt index0 base", 64'(rd_base), 64'h0000_4000);
  endtask

  task automatic t_null_fixed;
    logic [1:0] f; int lat, acks, a0;
    do_load(3'd0, 16'h0003, f, lat, acks, a0);
    check("R6 code fault", 64'(f), 64'd1);
    check("R6 code no read", 64'(acks), 64'd0);
    read_reg(3'd0);
    check("R6 code sel kept", 64'(rd_sel), 64'h000C);
    check("R6 code base kept", 64'(rd_base), 64'h80FF_0024);
    check("R6 code null kept", 64'(rd_null), 64'd0);
    do_load(3'd1, 16'h0001, f, lat, acks, a0);
    check("R6 stack fault", 64'(f), 64'd1);
    read_reg(3'd1);
    check("R6 stack sel kept", 64'(rd_sel), 64'h0000);
  endtask

  task automatic t_limits;
    logic [1:0] f; int lat, acks, a0;
    do_load(3'd2, 16'h0040, f, lat, acks, a0);
    check("R7 gdt over fault", 64'(f), 64'd2);
    check("R7 gdt over latency", 64'(lat), 64'd1);
    check("R7 gdt over no read", 64'(acks), 64'd0);
    put_desc(32'h138, 32'h0ABC_0000, 20'h00010, 1'b0, 1'b1, 2'b01, 1'b1, 4'h6);
    do_load(3'd2, 16'h0038, f, lat, acks, a0);
    check("R7 gdt at limit fault", 64'(f), 64'd0);
    check("R7 gdt at limit addr", 64'(ack_addr[a0 % 64]), 64'h138);
    do_load(3'd2, 16'h0024, f, lat, acks, a0);
    check("R7 ldt over fault", 64'(f), 64'd2);
    check("R7 ldt over no read", 64'(acks), 64'd0);
    put_desc(32'h218, 32'h0000_9000, 20'h00020, 1'b0, 1'b1, 2'b00, 1'b1, 4'h2);
    do_load(3'd2, 16'h001C, f, lat, acks, a0);
    check("R7 ldt at limit fault", 64'(f), 64'd0);
    read_reg(3'd2);
    check("R7 ldt at limit base", 64'(rd_base), 64'h0000_9000);
  endtask

  task automatic t_absent;
    logic [1:0] f; int lat, acks, a0;
    put_desc(32'h118, 32'hDEAD_BEEF, 20'h11111, 1'b1, 1'b0, 2'b00, 1'b1, 4'h2);
    do_load(3'd3, 16'h0018, f, lat, acks, a0);
    check("R8 fault", 64'(f), 64'd3);
    check("R8 did read", 64'(acks), 64'd2);
    read_reg(3'd3);
    check("R8 sel kept", 64'(rd_sel), 64'h0013);
    check("R8 base kept", 64'(rd_base), 64'h1234_5678);
  endtask

  task automatic t_busy;
    int d0, n;
    wait_cyc = 4;
    @(negedge clk);
    d0 = done_cnt;
    ld_reg = 3'd2; ld_sel = 16'h0010; ld_req = 1'b1;
    @(negedge clk);
    ld_reg = 3'd5; ld_sel = 16'h0003;
    repeat (3) @(negedge clk);
    ld_req = 1'b0;
    n = 0;
    while (!done && n < 100) begin @(negedge clk); n++; end
    repeat (4) @(negedge clk);
    #1;
    check("R10 single done", 64'(done_cnt - d0), 64'd1);
    read_reg(3'd5);
    check("R10 busy request ignored", 64'(rd_sel), 64'h0002);
    read_reg(3'd2);
    check("R10 first request done", 64'(rd_sel), 64'h0010);
    check("R10 first request base", 64'(rd_base), 64'h1234_5678);
    wait_cyc = 0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    t_reset();
    t_gdt_load();
    put_desc(32'h110, 32'h1234_5678, 20'hABCDE, 1'b1, 1'b1, 2'b10, 1'b1, 4'hA);
    t_ldt_load();
    t_null_data();
    t_null_fixed();
    t_limits();
    t_absent();
    t_busy();
    finish_run();
  end
endmodule